// File: doc/BRIEF.md
# Half-Bridge Switch Command Sequencer

This block turns logic-level commands into the two gate commands of one half-bridge: `p_on_o` closes the switch to the positive rail and `n_on_o` closes the switch to the negative rail. It has two ways of taking commands. In dual-input mode each switch has its own command pin. In single-input mode one pin chooses which rail the output connects to, and the block adds a dead band so that one switch has opened before the other closes. An active-low enable releases the output to high impedance. Two overcurrent flags each open the switch that carries the current. That switch then stays open for the rest of the pulse.

All timing is counted in clock cycles. `DEAD_CYC` is the dead band and `OC_OFF_CYC` is the minimum overcurrent off time. The defaults of 25 and 12 cycles give 200 ns and 96 ns at 125 MHz. Every pin is a plain level signal and there is no handshake. Commands are sampled on each rising clock edge, and the gate commands are registered.

Top module: `hb_gate_ctrl`

## Requirements
- R1: After reset, `p_on_o` and `n_on_o` are low and `out_state_o` is 2'b00.
- R2: While `en_n_i` is high, both gate commands are low from the next clock edge, whatever the other inputs are.
- R3: In dual-input mode (`mode_i` = 1), one cycle after sampling, `p_on_o` equals the inverse of `p_cmd_i` and `n_on_o` equals `n_cmd_i`. This holds while no overcurrent lock is active.
- R4: In dual-input mode, the combination `p_cmd_i` = 0 with `n_cmd_i` = 1 is forbidden. It turns both switches off, and the output goes high-Z.
- R5: In single-input mode (`mode_i` = 0), only `n_cmd_i` is used. When it is high the positive-rail switch is requested, and when it is low the negative-rail switch is requested. `p_cmd_i` has no effect.
- R6: In single-input mode, a switch closes only after both gate commands have been low for exactly `DEAD_CYC` consecutive cycles. This applies after a command change, after enable and after reset.
- R7: An overcurrent flag on `oc_src_i` passes through a two-stage synchronizer and then forces `p_on_o` low. The switch stays open for at least `OC_OFF_CYC` cycles. After that it closes again only once its command has gone inactive and then becomes active again.
- R8: `oc_snk_i` acts on `n_on_o` in the same way as R7 acts on `p_on_o`.
- R9: `p_on_o` and `n_on_o` are never high in the same cycle.
- R10: `out_state_o` is 2'b01 when `p_on_o` is high, 2'b10 when `n_on_o` is high, and 2'b00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1: dual-input mode, 0: single-input mode with dead band |
| p_cmd_i | input | 1 | Positive-switch command. When high in dual-input mode, it opens the switch |
| n_cmd_i | input | 1 | Negative-switch command in dual-input mode. Rail select in single-input mode |
| en_n_i | input | 1 | Active-low enable. When high, the output goes high-Z |
| oc_src_i | input | 1 | Source (positive-rail) overcurrent flag, asynchronous |
| oc_snk_i | input | 1 | Sink (negative-rail) overcurrent flag, asynchronous |
| p_on_o | output | 1 | Gate command for the positive-rail switch |
| n_on_o | output | 1 | Gate command for the negative-rail switch |
| out_state_o | output | 2 | Output state: 01 high, 10 low, 00 high-Z |

## Verification
Some rules are checked by the assertions on every clock. The two switches are never on together. Enable forces both off. The forbidden dual-input combination yields high-Z. In single-input mode, a switch closing is always preceded by a cycle in which both were off.

Other behaviour can only be shown by the bench's scenarios against its cycle model:
- the exact dead-band length;
- the synchronizer latency;
- how long an overcurrent lock lasts, and that it waits for a fresh command;
- the output state encoding.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    OUT_HIZ  = 2'b00,
    OUT_HIGH = 2'b01,
    OUT_LOW  = 2'b10
  } out_state_e;

  typedef struct packed {
    logic n;
    logic p;
  } sw_pair_t;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= d_i;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbg_cmd_map.sv
module hbg_cmd_map
  import hbg_pkg::*;
(
  input  logic     mode_i,
  input  logic     p_cmd_i,
  input  logic     n_cmd_i,
  input  logic     en_n_i,
  output sw_pair_t req_o
);
  always_comb begin
    req_o = '0;
    if (!en_n_i) begin
      if (mode_i) begin
        // dual-input: low p_cmd closes positive switch; forbidden overlap -> both open
        if (!(!p_cmd_i && n_cmd_i)) begin
          req_o.p = !p_cmd_i;
          req_o.n = n_cmd_i;
        end
      end else begin
        req_o.p = n_cmd_i;
        req_o.n = !n_cmd_i;
      end
    end
  end
endmodule

// File: rtl/hbg_oc_guard.sv
module hbg_oc_guard #(
  parameter int OFF_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic req_i,
  output logic block_o
);
  localparam int TW = $clog2(OFF_CYC + 1);

  logic [TW-1:0] tmr_q;
  logic          lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      lock_q <= 1'b0;
    end else if (trip_i) begin
      tmr_q  <= TW'(OFF_CYC);
      lock_q <= 1'b1;
    end else begin
      if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
      if (tmr_q == '0 && !req_i) lock_q <= 1'b0;
    end
  end

  assign block_o = lock_q | trip_i;
endmodule

// File: rtl/hbg_deadband.sv
module hbg_deadband
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 25
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_i,
  input  sw_pair_t req_i,
  output logic     p_on_o,
  output logic     n_on_o
);
  localparam int GW = $clog2(DEAD_CYC + 1);

  logic [GW-1:0] gap_q;
  logic          p_q, n_q, p_d, n_d;
  logic          both_off, gap_ok;

  assign both_off = !p_q && !n_q;
  assign gap_ok   = (gap_q >= GW'(DEAD_CYC - 1));

  always_comb begin
    if (mode_i) begin
      p_d = req_i.p;
      n_d = req_i.n;
    end else begin
      p_d = req_i.p && (p_q || (both_off && gap_ok));
      n_d = req_i.n && (n_q || (both_off && gap_ok));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q   <= 1'b0;
      n_q   <= 1'b0;
      gap_q <= '0;
    end else begin
      p_q <= p_d;
      n_q <= n_d;
      if (!both_off)                     gap_q <= '0;
      else if (gap_q != GW'(DEAD_CYC))   gap_q <= gap_q + 1'b1;
    end
  end

  assign p_on_o = p_q;
  assign n_on_o = n_q;
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC    = 25,
  parameter int OC_OFF_CYC  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_i,
  input  logic       p_cmd_i,
  input  logic       n_cmd_i,
  input  logic       en_n_i,
  input  logic       oc_src_i,
  input  logic       oc_snk_i,
  output logic       p_on_o,
  output logic       n_on_o,
  output logic [1:0] out_state_o
);
  localparam int NSW = 2;

  logic [NSW-1:0] trip_s, req_v, blk_v;
  sw_pair_t       req, req_gated;

  hbg_sync #(.WIDTH(NSW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({oc_snk_i, oc_src_i}),
    .q_o(trip_s)
  );

  hbg_cmd_map u_map (
    .mode_i(mode_i), .p_cmd_i(p_cmd_i), .n_cmd_i(n_cmd_i),
    .en_n_i(en_n_i), .req_o(req)
  );

  assign req_v = {req.n, req.p};

  for (genvar i = 0; i < NSW; i++) begin : g_guard
    hbg_oc_guard #(.OFF_CYC(OC_OFF_CYC)) u_guard (
      .clk(clk), .rst_n(rst_n),
      .trip_i(trip_s[i]), .req_i(req_v[i]),
      .block_o(blk_v[i])
    );
  end

  assign req_gated.p = req.p && !blk_v[0];
  assign req_gated.n = req.n && !blk_v[1];

  hbg_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .req_i(req_gated), .p_on_o(p_on_o), .n_on_o(n_on_o)
  );

  always_comb begin
    unique case ({n_on_o, p_on_o})
      2'b01:   out_state_o = OUT_HIGH;
      2'b10:   out_state_o = OUT_LOW;
      default: out_state_o = OUT_HIZ;
    endcase
  end
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_i,
  input logic p_cmd_i,
  input logic n_cmd_i,
  input logic en_n_i,
  input logic p_on_o,
  input logic n_on_o
);
  // R9
  never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_on_o && n_on_o));

  // R2
  disable_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |=> (!p_on_o && !n_on_o));

  // R4
  forbidden_combo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !en_n_i && !p_cmd_i && n_cmd_i) |=> (!p_on_o && !n_on_o));

  // R6
  p_rise_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !p_on_o && !n_on_o) |=> (!n_on_o || !p_on_o));

  // R6
  n_rise_needs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && p_on_o) |=> !n_on_o);

  // R6
  p_rise_needs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && n_on_o) |=> !p_on_o);
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .p_cmd_i(p_cmd_i),
  .n_cmd_i(n_cmd_i), .en_n_i(en_n_i), .p_on_o(p_on_o), .n_on_o(n_on_o)
);

// File: tb/hb_gate_ctrl_tb.sv
module hb_gate_ctrl_tb;
  localparam int DEAD = 25;
  localparam int OFFC = 12;

  logic clk = 0, rst_n = 0;
  logic mode_i = 1, p_cmd_i = 1, n_cmd_i = 0, en_n_i = 1, oc_src_i = 0, oc_snk_i = 0;
  logic p_on_o, n_on_o;
  logic [1:0] out_state_o;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R1 reset";

  hb_gate_ctrl #(.DEAD_CYC(DEAD), .OC_OFF_CYC(OFFC)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .p_cmd_i(p_cmd_i), .n_cmd_i(n_cmd_i),
    .en_n_i(en_n_i), .oc_src_i(oc_src_i), .oc_snk_i(oc_snk_i),
    .p_on_o(p_on_o), .n_on_o(n_on_o), .out_state_o(out_state_o));

  always #4 clk = ~clk;

  // behavioural reference
  bit sync_src[$], sync_snk[$];
  bit m_p, m_n, lk_p, lk_n;
  int gap, t_p, t_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_src = '{0, 0}; sync_snk = '{0, 0};
      m_p = 0; m_n = 0; lk_p = 0; lk_n = 0; gap = 0; t_p = 0; t_n = 0;
    end else begin
      bit tp, tn, rp, rn, wp, wn, np, nn, idle;
      tp = sync_src[0]; tn = sync_snk[0];
      void'(sync_src.pop_front()); void'(sync_snk.pop_front());
      sync_src.push_back(oc_src_i); sync_snk.push_back(oc_snk_i);
      rp = 0; rn = 0;
      if (!en_n_i) begin
        if (mode_i) begin
          if (!(p_cmd_i == 0 && n_cmd_i == 1)) begin rp = !p_cmd_i; rn = n_cmd_i; end
        end else begin rp = n_cmd_i; rn = !n_cmd_i; end
      end
      wp = rp && !(lk_p || tp);
      wn = rn && !(lk_n || tn);
      idle = !m_p && !m_n;
      if (mode_i) begin np = wp; nn = wn; end
      else begin
        np = wp && (m_p || (idle && gap + 1 >= DEAD));
        nn = wn && (m_n || (idle && gap + 1 >= DEAD));
      end
      if (!idle) gap = 0; else if (gap < DEAD) gap++;
      if (tp) begin t_p = OFFC; lk_p = 1; end
      else begin if (t_p == 0 && !rp) lk_p = 0; if (t_p > 0) t_p--; end
      if (tn) begin t_n = OFFC; lk_n = 1; end
      else begin if (t_n == 0 && !rn) lk_n = 0; if (t_n > 0) t_n--; end
      m_p = np; m_n = nn;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R3, R5, R7, R8, R10 by phase)
  always @(negedge clk) if (rst_n && !done) begin
    int es;
    es = m_p ? 1 : (m_n ? 2 : 0);
    chk({phase, " p_on"}, p_on_o, m_p);
    chk({phase, " n_on"}, n_on_o, m_n);
    chk({phase, " R10 state"}, out_state_o, es);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [15:0] lf;
    cyc(3);
    chk("R1 p_on", p_on_o, 0); chk("R1 n_on", n_on_o, 0); chk("R1 state", out_state_o, 0);
    rst_n = 1;
    // R2: disabled, sweep inputs
    phase = "R2 disabled";
    for (int i = 0; i < 8; i++) begin
      mode_i = i[0]; p_cmd_i = i[1]; n_cmd_i = i[2]; cyc(2);
      chk("R2 both off", p_on_o | n_on_o, 0);
    end
    // R3 / R4 dual-input
    phase = "R3 dual"; mode_i = 1; en_n_i = 0;
    p_cmd_i = 0; n_cmd_i = 0; cyc(2); chk("R3 high", out_state_o, 1);
    p_cmd_i = 1; n_cmd_i = 0; cyc(2); chk("R3 hiz", out_state_o, 0);
    p_cmd_i = 1; n_cmd_i = 1; cyc(2); chk("R3 low", out_state_o, 2);
    phase = "R4 forbidden";
    p_cmd_i = 0; n_cmd_i = 1; cyc(2); chk("R4 hiz", out_state_o, 0);
    // R5 / R6 single-input
    phase = "R5 single"; mode_i = 0; n_cmd_i = 1; p_cmd_i = 0; cyc(DEAD + 4);
    chk("R5 high", out_state_o, 1);
    p_cmd_i = 1; cyc(3); chk("R5 p_cmd ignored", out_state_o, 1);
    phase = "R6 deadband"; n_cmd_i = 0; cyc(1);
    cnt = 0;
    while (!n_on_o && cnt < 200) begin chk("R6 p off", p_on_o, 0); cnt++; cyc(1); end
    chk("R6 gap length", cnt, DEAD);
    chk("R5 low", out_state_o, 2);
    // R7 source overcurrent in dual mode
    phase = "R7 src oc"; mode_i = 1; p_cmd_i = 0; n_cmd_i = 0; cyc(3);
    chk("R7 on before", p_on_o, 1);
    oc_src_i = 1; cyc(1); oc_src_i = 0; cyc(3);
    chk("R7 tripped", p_on_o, 0);
    cyc(OFFC + 30); chk("R7 still locked", p_on_o, 0);
    p_cmd_i = 1; cyc(2); p_cmd_i = 0; cyc(2);
    chk("R7 restored", p_on_o, 1);
    // R8 sink overcurrent in single mode
    phase = "R8 snk oc"; mode_i = 0; n_cmd_i = 0; cyc(DEAD + 4);
    chk("R8 on before", n_on_o, 1);
    oc_snk_i = 1; cyc(1); oc_snk_i = 0; cyc(3);
    chk("R8 tripped", n_on_o, 0);
    cyc(OFFC + 30); chk("R8 still locked", n_on_o, 0);
    n_cmd_i = 1; cyc(2); n_cmd_i = 0; cyc(DEAD + 4);
    chk("R8 restored", n_on_o, 1);
    // mixed pseudo-random sweep
    phase = "R3 R5 R7 R8 sweep"; lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 0) mode_i = lf[4];
      p_cmd_i = (lf[7:5] == 0) ? ~p_cmd_i : p_cmd_i;
      n_cmd_i = (lf[10:8] == 0) ? ~n_cmd_i : n_cmd_i;
      en_n_i = (lf[15:11] == 0);
      oc_src_i = (lf[14:9] == 6'h3F);
      oc_snk_i = (lf[13:8] == 6'h15);
      cyc(1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule